// File: doc/BRIEF.md
# Sector-Buffered Flash Program Controller

This block is the control path of a flash array that is only ever rewritten one whole 256-byte sector at a time. A host drives an SRAM-style bus: address, an 8-bit data bus, and active-low chip enable, output enable and write enable. The host first raises a one-cycle unlock pulse, which stands for an upstream command decoder that has recognised the unlock sequence. It then issues byte loads, in any order, into a staging buffer that belongs to one sector. There is no commit command. The load window closes on its own once the bus has stayed free of write strobes for a programmable number of clock cycles.

After the window closes, the block waits out a timed program period. It then copies the whole sector into the array, which is modelled as a synchronous RAM. Every byte that was not loaded is written as all ones, so the old contents are erased as part of the same pass. While the block is busy, reads return a polling byte: its bit 7 is the inverse of bit 7 of the last byte loaded. A write made without unlocking first stores nothing. It still runs the program timer, and reads poll during that time.

Top module: `flash_sector_prog`

## Requirements
- R1: After reset, `busy_o` is 0 and `dout_o` is 8'h00.
- R2: The address splits into three fields. Bits [3:0] are the low offset nibble. Bits [SEC_W+3:4] are the sector number. The top four bits are the high offset nibble. The offset inside the sector is {high nibble, low nibble}, and each loaded byte lands at its own offset whatever the load order.
- R3: After a commit, every offset of the programmed sector that received no load in that window reads 8'hFF.
- R4: The load window stays open while fewer than TIMEOUT_CYC consecutive clock edges see no write strobe. With the last byte's data captured at edge E0, `busy_o` is still 0 after edge E0+TIMEOUT_CYC-2 and is 1 after edge E0+TIMEOUT_CYC-1.
- R5: For an unlocked load, `busy_o` stays high for exactly PROG_CYC+256 cycles: the program period followed by one array write per offset.
- R6: A read made while `busy_o` is high returns {~L[7], L[6:0]}, where L is the last byte loaded.
- R7: A write made without a preceding unlock leaves the array unchanged. It holds `busy_o` high for exactly PROG_CYC cycles, and reads during that time poll against the written byte.
- R8: Within one window, a load whose sector field differs from that of the first load is dropped.
- R9: A read (chip enable and output enable low, write enable high) updates `dout_o` one clock later, and `dout_o` holds when no read is made. A read during an open load window returns the array's current contents.
- R10: Writes made while `busy_o` is high are ignored.
- R11: The address is taken on the first edge that sees the write strobe (chip enable and write enable both low) active. The data is taken on the first edge that sees the strobe inactive again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock_i | input | 1 | One-cycle pulse that permits the next load window |
| addr_i | input | SEC_W+8 | Byte address (low nibble, sector, high nibble) |
| din_i | input | 8 | Write data |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| dout_o | output | 8 | Read data or polling byte |
| busy_o | output | 1 | High from window close until the commit ends |

## Verification
Read data arrives one clock after the edge that samples the read. The bench therefore raises the enables on one falling edge, drops them on the next, and samples `dout_o` at that same falling edge. The window-close instant is due TIMEOUT_CYC-1 edges after the data-capture edge of the last byte. It is checked from the falling edge on which the strobe was released: once one edge before the close is due and once just after it. The busy length is counted on falling edges by a separate counter and compared with PROG_CYC+256, or with PROG_CYC for a write made without unlocking. Array contents are read back only after `busy_o` has fallen, and each value is compared with a bench model of buffer, mask and erase fill.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOAD   = 2'd1,
      ST_PROG   = 2'd2,
      ST_COMMIT = 2'd3
   } prog_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/flash_sector_buf.sv
module flash_sector_buf
   import flash_prog_pkg::*;
#(
   parameter int unsigned OFF_W      = 8,
   parameter bit          ERASE_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [OFF_W-1:0]  waddr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic [OFF_W-1:0]  raddr_i,
   output logic [BYTE_W-1:0] rbyte_o
);

   localparam int unsigned SLOTS = 2 ** OFF_W;

   logic [BYTE_W-1:0] sbuf [SLOTS];
   logic [SLOTS-1:0]  loaded;
   logic [BYTE_W-1:0] fill;

   generate
      if (ERASE_ONES) begin : g_fill_ones
         assign fill = {BYTE_W{1'b1}};
      end else begin : g_fill_zero
         assign fill = {BYTE_W{1'b0}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded <= '0;
      end else if (clr_i) begin
         loaded <= '0;
      end else if (we_i) begin
         loaded[waddr_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (we_i) begin
         sbuf[waddr_i] <= wdata_i;
      end
   end

   assign rbyte_o = loaded[raddr_i] ? sbuf[raddr_i] : fill;

   // R3: clearing the mask and loading a byte never coincide
   p_clr_we_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_i && we_i));

endmodule

// File: rtl/flash_array_ram.sv
module flash_array_ram
   import flash_prog_pkg::*;
#(
   parameter int unsigned AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [BYTE_W-1:0] rdata_o
);

   localparam int unsigned DEPTH = 2 ** AW;

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (re_i) begin
         rdata_o <= mem[raddr_i];
      end
   end

endmodule

// File: rtl/flash_load_ctrl.sv
module flash_load_ctrl
   import flash_prog_pkg::*;
#(
   parameter int unsigned SEC_W       = 3,
   parameter int unsigned OFF_W       = 8,
   parameter int unsigned TIMEOUT_CYC = 37500,
   parameter int unsigned PROG_CYC    = 2500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unlock_i,
   input  logic              strobe_i,
   input  logic [SEC_W-1:0]  sec_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [BYTE_W-1:0] din_i,
   output logic              buf_clr_o,
   output logic              buf_we_o,
   output logic [OFF_W-1:0]  buf_waddr_o,
   output logic [BYTE_W-1:0] buf_wdata_o,
   output logic [OFF_W-1:0]  cmt_idx_o,
   output logic              ram_we_o,
   output logic [SEC_W-1:0]  ram_sec_o,
   output logic              busy_o,
   output logic [BYTE_W-1:0] last_o
);

   localparam int unsigned GAP_W = $clog2(TIMEOUT_CYC + 1);
   localparam int unsigned PC_W  = $clog2(PROG_CYC + 1);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(TIMEOUT_CYC - 1);
   localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PROG_CYC - 1);

   initial begin
      assert (TIMEOUT_CYC >= 3) else $error("TIMEOUT_CYC must be at least 3");
      assert (PROG_CYC >= 2) else $error("PROG_CYC must be at least 2");
   end

   prog_state_e       state;
   logic              strobe_q;
   logic              armed;
   logic              pend_rej;
   logic              cap_ok;
   logic [OFF_W-1:0]  cap_off;
   logic [SEC_W-1:0]  sec_q;
   logic [GAP_W-1:0]  gap;
   logic [PC_W-1:0]   pc;
   logic [OFF_W-1:0]  idx;
   logic              commit_en;
   logic [BYTE_W-1:0] last_q;

   logic st_start;
   logic st_end;

   assign st_start = strobe_i & ~strobe_q;
   assign st_end   = ~strobe_i & strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         strobe_q  <= 1'b0;
         armed     <= 1'b0;
         pend_rej  <= 1'b0;
         cap_ok    <= 1'b0;
         cap_off   <= '0;
         sec_q     <= '0;
         gap       <= '0;
         pc        <= '0;
         idx       <= '0;
         commit_en <= 1'b0;
         last_q    <= '0;
      end else begin
         strobe_q <= strobe_i;
         if (unlock_i && state == ST_IDLE && !pend_rej) begin
            armed <= 1'b1;
         end
         case (state)
            ST_IDLE: begin
               if (st_start) begin
                  if (armed) begin
                     state   <= ST_LOAD;
                     sec_q   <= sec_i;
                     cap_off <= off_i;
                     cap_ok  <= 1'b1;
                     armed   <= 1'b0;
                     gap     <= '0;
                  end else begin
                     pend_rej <= 1'b1;
                  end
               end else if (st_end && pend_rej) begin
                  pend_rej  <= 1'b0;
                  last_q    <= din_i;
                  commit_en <= 1'b0;
                  pc        <= '0;
                  state     <= ST_PROG;
               end
            end
            ST_LOAD: begin
               if (st_start) begin
                  cap_off <= off_i;
                  cap_ok  <= (sec_i == sec_q);
               end
               if (st_end && cap_ok) begin
                  last_q <= din_i;
               end
               if (strobe_i) begin
                  gap <= '0;
               end else if (gap == GAP_LAST) begin
                  state     <= ST_PROG;
                  pc        <= '0;
                  commit_en <= 1'b1;
               end else begin
                  gap <= gap + 1'b1;
               end
            end
            ST_PROG: begin
               if (pc == PC_LAST) begin
                  if (commit_en) begin
                     state <= ST_COMMIT;
                     idx   <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            ST_COMMIT: begin
               if (&idx) begin
                  state <= ST_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign buf_clr_o   = (state == ST_IDLE) && st_start && armed;
   assign buf_we_o    = (state == ST_LOAD) && st_end && cap_ok;
   assign buf_waddr_o = cap_off;
   assign buf_wdata_o = din_i;
   assign cmt_idx_o   = idx;
   assign ram_we_o    = (state == ST_COMMIT);
   assign ram_sec_o   = sec_q;
   assign busy_o      = (state == ST_PROG) || (state == ST_COMMIT);
   assign last_o      = last_q;

   // R4: the window only closes on an edge that saw no strobe
   p_close_on_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_LOAD && state == ST_PROG) |-> $past(!strobe_i));

   // R5: the commit walks every offset in ascending order
   p_commit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COMMIT && $past(state) == ST_COMMIT) |-> idx == $past(idx) + 1'b1);

   // R7: a program period entered straight from idle never commits
   p_reject_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_IDLE && state == ST_PROG) |-> !commit_en);

endmodule

// File: rtl/flash_sector_prog.sv
module flash_sector_prog
   import flash_prog_pkg::*;
#(
   parameter int unsigned SEC_W       = 3,
   parameter int unsigned LO_W        = 4,
   parameter int unsigned HI_W        = 4,
   parameter int unsigned TIMEOUT_CYC = 37500,
   parameter int unsigned PROG_CYC    = 2500000,
   parameter bit          ERASE_ONES  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        unlock_i,
   input  logic [LO_W+SEC_W+HI_W-1:0]  addr_i,
   input  logic [7:0]                  din_i,
   input  logic                        ce_n_i,
   input  logic                        oe_n_i,
   input  logic                        we_n_i,
   output logic [7:0]                  dout_o,
   output logic                        busy_o
);

   localparam int unsigned OFF_W = LO_W + HI_W;
   localparam int unsigned RAM_W = SEC_W + OFF_W;

   initial begin
      assert (OFF_W == 8) else $error("sector offset must be 8 bits wide");
      assert (SEC_W >= 1 && SEC_W <= 11) else $error("SEC_W out of range");
   end

   logic [SEC_W-1:0]  sec;
   logic [OFF_W-1:0]  off;
   logic              strobe;
   logic              rd_en;

   logic              buf_clr;
   logic              buf_we;
   logic [OFF_W-1:0]  buf_waddr;
   logic [BYTE_W-1:0] buf_wdata;
   logic [OFF_W-1:0]  cmt_idx;
   logic [BYTE_W-1:0] cmt_byte;
   logic              ram_we;
   logic [SEC_W-1:0]  ram_sec;
   logic [BYTE_W-1:0] ram_rdata;
   logic [BYTE_W-1:0] last_byte;
   logic              busy;

   logic              poll_sel;
   logic [BYTE_W-1:0] poll_byte;

   assign sec    = addr_i[LO_W +: SEC_W];
   assign off    = {addr_i[LO_W+SEC_W +: HI_W], addr_i[LO_W-1:0]};
   assign strobe = ~ce_n_i & ~we_n_i;
   assign rd_en  = ~ce_n_i & ~oe_n_i & we_n_i;

   flash_load_ctrl #(
      .SEC_W       (SEC_W),
      .OFF_W       (OFF_W),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .PROG_CYC    (PROG_CYC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .unlock_i    (unlock_i),
      .strobe_i    (strobe),
      .sec_i       (sec),
      .off_i       (off),
      .din_i       (din_i),
      .buf_clr_o   (buf_clr),
      .buf_we_o    (buf_we),
      .buf_waddr_o (buf_waddr),
      .buf_wdata_o (buf_wdata),
      .cmt_idx_o   (cmt_idx),
      .ram_we_o    (ram_we),
      .ram_sec_o   (ram_sec),
      .busy_o      (busy),
      .last_o      (last_byte)
   );

   flash_sector_buf #(
      .OFF_W      (OFF_W),
      .ERASE_ONES (ERASE_ONES)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (buf_clr),
      .we_i    (buf_we),
      .waddr_i (buf_waddr),
      .wdata_i (buf_wdata),
      .raddr_i (cmt_idx),
      .rbyte_o (cmt_byte)
   );

   flash_array_ram #(
      .AW (RAM_W)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ram_we),
      .waddr_i ({ram_sec, cmt_idx}),
      .wdata_i (cmt_byte),
      .re_i    (rd_en),
      .raddr_i ({sec, off}),
      .rdata_o (ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_sel  <= 1'b0;
         poll_byte <= '0;
      end else if (rd_en) begin
         poll_sel  <= busy;
         poll_byte <= {~last_byte[7], last_byte[6:0]};
      end
   end

   assign dout_o = poll_sel ? poll_byte : ram_rdata;
   assign busy_o = busy;

   // R6: a read sampled while busy returns the polling byte
   p_poll_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_en) && $past(busy)) |->
         dout_o == {~$past(last_byte[7]), $past(last_byte[6:0])});

   // R9: output holds when no read was sampled
   p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> $stable(dout_o));

endmodule

// File: tb/flash_sector_prog_bench.sv
module flash_sector_prog_bench;

   localparam int TO  = 24;
   localparam int PC  = 50;
   localparam int AW  = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          unlock_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [7:0]    din_i = '0;
   logic          ce_n_i = 1'b1;
   logic          oe_n_i = 1'b1;
   logic          we_n_i = 1'b1;
   logic [7:0]    dout_o;
   logic          busy_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int run = 0;
   int last_run = 0;

   logic [7:0] exp_mem [0:2047];
   logic [7:0] sbuf    [0:255];
   bit         sload   [0:255];
   logic [7:0] last_ld;

   always #2 clk = ~clk;

   flash_sector_prog #(
      .TIMEOUT_CYC (TO),
      .PROG_CYC    (PC)
   ) u_flash_sector_prog (
      .clk      (clk),
      .rst_n    (rst_n),
      .unlock_i (unlock_i),
      .addr_i   (addr_i),
      .din_i    (din_i),
      .ce_n_i   (ce_n_i),
      .oe_n_i   (oe_n_i),
      .we_n_i   (we_n_i),
      .dout_o   (dout_o),
      .busy_o   (busy_o)
   );

   always @(negedge clk) begin
      if (busy_o) run = run + 1;
      else if (run != 0) begin
         last_run = run;
         run = 0;
      end
   end

   function automatic logic [AW-1:0] mk(input int s, input int o);
      logic [7:0] ob;
      logic [2:0] sb;
      ob = 8'(o);
      sb = 3'(s);
      return {ob[7:4], sb, ob[3:0]};
   endfunction

   function automatic logic [7:0] poll_of(input logic [7:0] b);
      return {~b[7], b[6:0]};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic arm();
      @(negedge clk); unlock_i = 1'b1;
      @(negedge clk); unlock_i = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); addr_i = a; din_i = d; ce_n_i = 1'b0; we_n_i = 1'b0;
      @(negedge clk);
      @(negedge clk); ce_n_i = 1'b1; we_n_i = 1'b1;
   endtask

   task automatic wr_shift(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                           input logic [7:0] d1, input logic [7:0] d2);
      @(negedge clk); addr_i = a1; din_i = d1; ce_n_i = 1'b0; we_n_i = 1'b0;
      @(negedge clk); addr_i = a2; din_i = d2;
      @(negedge clk); ce_n_i = 1'b1; we_n_i = 1'b1;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk); addr_i = a; ce_n_i = 1'b0; oe_n_i = 1'b0;
      @(negedge clk); ce_n_i = 1'b1; oe_n_i = 1'b1;
      d = dout_o;
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_model();
      for (int i = 0; i < 256; i++) begin
         sload[i] = 0;
         sbuf[i]  = 8'h00;
      end
   endtask

   task automatic commit_model(input int s);
      for (int i = 0; i < 256; i++)
         exp_mem[s*256 + i] = sload[i] ? sbuf[i] : 8'hFF;
   endtask

   initial begin
      logic [7:0] d;
      int o;
      int n;
      void'($urandom(32'd4242));
      for (int i = 0; i < 2048; i++) exp_mem[i] = 8'h00;
      repeat (5) @(negedge clk);
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 dout", int'(dout_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sector 2: random loads in random order
      clear_model();
      arm();
      n = 30;
      for (int i = 0; i < n; i++) begin
         o = int'($urandom % 256);
         d = 8'($urandom);
         wr(mk(2, o), d);
         sbuf[o] = d; sload[o] = 1; last_ld = d;
         repeat (int'($urandom % (TO - 4))) @(negedge clk);
      end
      // R11: address from strobe start, data from strobe end
      wr_shift(mk(2, 200), mk(2, 201), 8'h11, 8'hE7);
      sbuf[200] = 8'hE7; sload[200] = 1; last_ld = 8'hE7;
      repeat (TO - 1) @(negedge clk);
      chk("R4 window still open", int'(busy_o), 0);
      @(negedge clk);
      chk("R4 window closed", int'(busy_o), 1);
      rd(mk(0, 0), d);
      chk("R6 poll byte", int'(d), int'(poll_of(last_ld)));
      wr(mk(2, 200), 8'h5A);  // R10: ignored while busy
      wait_idle();
      chk("R5 busy length", last_run, PC + 256);
      commit_model(2);
      for (int i = 0; i < 256; i++) begin
         rd(mk(2, i), d);
         if (sload[i]) chk("R2 loaded byte", int'(d), int'(exp_mem[2*256+i]));
         else          chk("R3 erased byte", int'(d), 8'hFF);
      end
      rd(mk(2, 200), d);
      chk("R11 shifted strobe data", int'(d), 8'hE7);
      chk("R10 write while busy", int'(d), int'(exp_mem[2*256+200]));

      // Sector 1: directed window, foreign sector, read in window
      clear_model();
      arm();
      wr(mk(1, 10), 8'hA1);
      sbuf[10] = 8'hA1; sload[10] = 1;
      repeat (TO - 5) @(negedge clk);
      rd(mk(2, 5), d);
      chk("R9 read in open window", int'(d), int'(exp_mem[2*256+5]));
      chk("R4 open before timeout", int'(busy_o), 0);
      wr(mk(6, 10), 8'hB2);  // R8: foreign sector dropped
      wr(mk(1, 11), 8'h43);
      sbuf[11] = 8'h43; sload[11] = 1;
      repeat (2) @(negedge clk);
      chk("R4 restarted window", int'(busy_o), 0);
      repeat (TO) @(negedge clk);
      rd(mk(1, 0), d);
      chk("R6 poll second window", int'(d), int'(poll_of(8'h43)));
      wait_idle();
      chk("R5 busy length second", last_run, PC + 256);
      commit_model(1);
      rd(mk(1, 10), d);
      chk("R8 foreign load dropped", int'(d), 8'hA1);
      rd(mk(1, 11), d);
      chk("R2 second byte", int'(d), 8'h43);
      rd(mk(1, 12), d);
      chk("R3 erased second", int'(d), 8'hFF);
      rd(mk(1, 255), d);
      chk("R3 erased top offset", int'(d), 8'hFF);

      // Write without unlock
      wr(mk(2, 0), 8'h3C);
      @(negedge clk);
      chk("R7 busy on rejected write", int'(busy_o), 1);
      rd(mk(2, 0), d);
      chk("R7 poll rejected", int'(d), 8'hBC);
      wait_idle();
      chk("R7 busy length", last_run, PC);
      rd(mk(2, 0), d);
      chk("R7 array unchanged", int'(d), int'(exp_mem[2*256]));
      repeat (3) @(negedge clk);
      chk("R9 dout holds", int'(dout_o), int'(exp_mem[2*256]));

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule